// File: doc/BRIEF.md
# UART FIFO DMA Request Generator

This block drives the two DMA request lines of a UART whose receiver and transmitter each sit behind a 16-entry FIFO. The receive line asks the DMA controller to drain the receive FIFO. It is raised when the fill level reaches a programmable threshold, or when the receiver reports a character timeout. The transmit line asks for more data to send. It is raised when the transmit FIFO stops being full.

Both lines are sticky. Once a request is raised, it stays high until the DMA controller pulses the matching clear strobe. If a raising event and a clear strobe arrive in the same cycle, the request stays high. While DMA mode is off, no request can be raised, and any pending request is dropped.

All outputs are registered. A request changes on the clock edge that follows the cycle in which its cause is seen.

Top module: `uart_dma_req_gen`

## Requirements
- R1: While reset is held and after it is released, with no event seen, both `rx_dma_req` and `tx_dma_req` are low.
- R2: With `dma_mode` high, `rx_dma_req` is high one cycle after `rx_fill` is equal to or greater than the selected threshold. `rx_trig_sel` 0, 1, 2 and 3 select the thresholds 1, 4, 8 and 14 entries.
- R3: With `dma_mode` high, a one-cycle `rx_char_tmo` pulse raises `rx_dma_req` one cycle later, even when `rx_fill` is below the threshold.
- R4: Once high, `rx_dma_req` stays high while `rx_clr` is low, even if `rx_fill` falls to zero.
- R5: `rx_clr` drops `rx_dma_req` one cycle later unless a receive raising event (level at or above threshold, or timeout) occurs in that same cycle. In that case the request stays high.
- R6: With `dma_mode` high, `tx_dma_req` is high one cycle after a cycle in which `tx_full` is low and `tx_full` was high in the previous cycle.
- R7: Once high, `tx_dma_req` stays high until `tx_clr`. A `tx_full` that stays low raises no new request after a clear. A full-to-not-full edge in the same cycle as `tx_clr` keeps the request high.
- R8: With `dma_mode` low, both requests are low one cycle later, and no level, timeout or edge raises them.
- R9: `rx_clr` has no effect on `tx_dma_req`, and `tx_clr` has no effect on `rx_dma_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_mode | input | 1 | DMA mode enable |
| rx_fill | input | 5 | Receive FIFO occupancy, 0 to 16 |
| rx_trig_sel | input | 2 | Receive threshold code (1, 4, 8, 14 entries) |
| rx_char_tmo | input | 1 | Character-timeout pulse from the receiver |
| rx_clr | input | 1 | Receive request clear strobe from the DMA controller |
| tx_full | input | 1 | Transmit FIFO full flag |
| tx_clr | input | 1 | Transmit request clear strobe from the DMA controller |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
The bench walks each threshold code right below and right at its threshold. A design with an off-by-one compare, or with swapped codes, would raise the request one entry early or late. It clears a receive request while the level is still above the threshold and while a timeout arrives. A design where the clear wins would drop a request that ought to stay, and a level-only design would never react to the timeout. On the transmit side, the bench holds the FIFO not full for many cycles after a clear. A design that uses the level instead of the edge would re-raise at once. The bench also toggles DMA mode with events pending and checks that each clear strobe leaves the other request alone.

// File: rtl/uart_dma_req_pkg.sv
package uart_dma_req_pkg;

    typedef struct packed {
        logic req;
    } rx_state_t;

    typedef struct packed {
        logic req;
        logic full_prev;
    } tx_state_t;

endpackage

// File: rtl/uart_dma_rx_req.sv
module uart_dma_rx_req
    import uart_dma_req_pkg::*;
#(
    parameter int LVL_W = 5,
    parameter int TRIG0 = 1,
    parameter int TRIG1 = 4,
    parameter int TRIG2 = 8,
    parameter int TRIG3 = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [LVL_W-1:0] fill,
    input  logic [1:0]       trig_sel,
    input  logic             char_tmo,
    input  logic             clr,
    output logic             req
);

    logic [LVL_W-1:0] thresh;
    logic             hit;
    rx_state_t        st_d, st_q;

    always_comb begin
        case (trig_sel)
            2'd0:    thresh = LVL_W'(TRIG0);
            2'd1:    thresh = LVL_W'(TRIG1);
            2'd2:    thresh = LVL_W'(TRIG2);
            default: thresh = LVL_W'(TRIG3);
        endcase
    end

    always_comb begin
        hit  = (fill >= thresh) || char_tmo;
        st_d = st_q;
        if (!enable) begin
            st_d.req = 1'b0;
        end else if (hit) begin
            st_d.req = 1'b1;
        end else if (clr) begin
            st_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req = st_q.req;

endmodule

// File: rtl/uart_dma_tx_req.sv
module uart_dma_tx_req
    import uart_dma_req_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic full,
    input  logic clr,
    output logic req
);

    logic      drained;
    tx_state_t st_d, st_q;

    always_comb begin
        drained      = st_q.full_prev && !full;
        st_d         = st_q;
        st_d.full_prev = full;
        if (!enable) begin
            st_d.req = 1'b0;
        end else if (drained) begin
            st_d.req = 1'b1;
        end else if (clr) begin
            st_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req = st_q.req;

endmodule

// File: rtl/uart_dma_req_gen.sv
module uart_dma_req_gen #(
    parameter int FIFO_DEPTH = 16,
    parameter int TRIG0      = 1,
    parameter int TRIG1      = 4,
    parameter int TRIG2      = 8,
    parameter int TRIG3      = 14,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dma_mode,
    input  logic [LVL_W-1:0] rx_fill,
    input  logic [1:0]       rx_trig_sel,
    input  logic             rx_char_tmo,
    input  logic             rx_clr,
    input  logic             tx_full,
    input  logic             tx_clr,
    output logic             rx_dma_req,
    output logic             tx_dma_req
);

    uart_dma_rx_req #(
        .LVL_W (LVL_W),
        .TRIG0 (TRIG0),
        .TRIG1 (TRIG1),
        .TRIG2 (TRIG2),
        .TRIG3 (TRIG3)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (dma_mode),
        .fill     (rx_fill),
        .trig_sel (rx_trig_sel),
        .char_tmo (rx_char_tmo),
        .clr      (rx_clr),
        .req      (rx_dma_req)
    );

    uart_dma_tx_req u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (dma_mode),
        .full   (tx_full),
        .clr    (tx_clr),
        .req    (tx_dma_req)
    );

endmodule

// File: rtl/uart_dma_req_chk.sv
module uart_dma_req_chk #(
    parameter int LVL_W = 5,
    parameter int TRIG0 = 1,
    parameter int TRIG1 = 4,
    parameter int TRIG2 = 8,
    parameter int TRIG3 = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dma_mode,
    input logic [LVL_W-1:0] rx_fill,
    input logic [1:0]       rx_trig_sel,
    input logic             rx_char_tmo,
    input logic             rx_clr,
    input logic             tx_full,
    input logic             tx_clr,
    input logic             rx_dma_req,
    input logic             tx_dma_req
);

    logic             seen_full;
    logic [LVL_W-1:0] lim;
    logic             rx_event;
    logic             tx_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_full <= 1'b0;
        else        seen_full <= tx_full;
    end

    always_comb begin
        unique case (rx_trig_sel)
            2'd0: lim = LVL_W'(TRIG0);
            2'd1: lim = LVL_W'(TRIG1);
            2'd2: lim = LVL_W'(TRIG2);
            2'd3: lim = LVL_W'(TRIG3);
        endcase
    end

    assign rx_event = (rx_fill >= lim) || rx_char_tmo;
    assign tx_edge  = seen_full && !tx_full;

    p_reset_low_r1: assert property (@(posedge clk)
        !rst_n |=> (!rx_dma_req && !tx_dma_req));

    p_rx_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_mode && rx_fill >= lim) |=> rx_dma_req);

    p_rx_timeout_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_mode && rx_char_tmo) |=> rx_dma_req);

    p_rx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_mode && rx_dma_req && !rx_clr) |=> rx_dma_req);

    p_rx_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_clr && !rx_event) |=> !rx_dma_req);

    p_tx_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_mode && tx_edge) |=> tx_dma_req);

    p_tx_no_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_dma_req && !tx_edge) |=> !tx_dma_req);

    p_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_mode |=> (!rx_dma_req && !tx_dma_req));

    p_rx_clr_iso_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_mode && tx_dma_req && rx_clr && !tx_clr) |=> tx_dma_req);

endmodule

bind uart_dma_req_gen uart_dma_req_chk #(
    .LVL_W (LVL_W),
    .TRIG0 (TRIG0),
    .TRIG1 (TRIG1),
    .TRIG2 (TRIG2),
    .TRIG3 (TRIG3)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dma_mode    (dma_mode),
    .rx_fill     (rx_fill),
    .rx_trig_sel (rx_trig_sel),
    .rx_char_tmo (rx_char_tmo),
    .rx_clr      (rx_clr),
    .tx_full     (tx_full),
    .tx_clr      (tx_clr),
    .rx_dma_req  (rx_dma_req),
    .tx_dma_req  (tx_dma_req)
);

// File: tb/uart_dma_req_gen_bench.sv
`timescale 1ns/1ps
module uart_dma_req_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dma_mode = 1'b0;
    logic [4:0] rx_fill = '0;
    logic [1:0] rx_trig_sel = '0;
    logic       rx_char_tmo = 1'b0;
    logic       rx_clr = 1'b0;
    logic       tx_full = 1'b0;
    logic       tx_clr = 1'b0;
    logic       rx_dma_req;
    logic       tx_dma_req;

    always #10 clk = ~clk;

    uart_dma_req_gen u_uart_dma_req_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .dma_mode    (dma_mode),
        .rx_fill     (rx_fill),
        .rx_trig_sel (rx_trig_sel),
        .rx_char_tmo (rx_char_tmo),
        .rx_clr      (rx_clr),
        .tx_full     (tx_full),
        .tx_clr      (tx_clr),
        .rx_dma_req  (rx_dma_req),
        .tx_dma_req  (tx_dma_req)
    );

    typedef struct {
        logic  rx;
        logic  tx;
        string tag;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 0;

    logic m_rx = 0, m_tx = 0, m_full_prev = 0;

    function automatic int thr(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic dm, input int lvl, input logic [1:0] sel, input logic to,
                        input logic rc, input logic full, input logic tc, input string tag);
        logic rset, tset;
        @(negedge clk);
        dma_mode = dm; rx_fill = 5'(lvl); rx_trig_sel = sel; rx_char_tmo = to;
        rx_clr = rc; tx_full = full; tx_clr = tc;
        rset = dm && ((lvl >= thr(sel)) || to);
        tset = dm && m_full_prev && !full;
        if (!dm)       m_rx = 0;
        else if (rset) m_rx = 1;
        else if (rc)   m_rx = 0;
        if (!dm)       m_tx = 0;
        else if (tset) m_tx = 1;
        else if (tc)   m_tx = 0;
        m_full_prev = full;
        q.push_back('{rx: m_rx, tx: m_tx, tag: tag});
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                it = q.pop_front();
                chk(rx_dma_req, it.rx, it.tag, "rx_dma_req");
                chk(tx_dma_req, it.tx, it.tag, "tx_dma_req");
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        #2;
        chk(rx_dma_req, 1'b0, "R1", "rx in reset");
        chk(tx_dma_req, 1'b0, "R1", "tx in reset");
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, 0, "R1");
        // R2 thresholds, code 0 -> 1 entry
        step(1, 0, 0, 0, 0, 0, 0, "R2");
        step(1, 1, 0, 0, 0, 0, 0, "R2");
        step(1, 1, 0, 0, 1, 0, 0, "R5");   // set wins over clear
        step(1, 0, 0, 0, 0, 0, 0, "R4");   // drained, still held
        step(1, 0, 0, 0, 0, 0, 0, "R4");
        step(1, 0, 0, 0, 1, 0, 0, "R5");
        // code 1 -> 4
        step(1, 3, 1, 0, 0, 0, 0, "R2");
        step(1, 4, 1, 0, 0, 0, 0, "R2");
        step(1, 0, 1, 0, 1, 0, 0, "R5");
        // code 2 -> 8
        step(1, 7, 2, 0, 0, 0, 0, "R2");
        step(1, 8, 2, 0, 0, 0, 0, "R2");
        step(1, 2, 2, 0, 1, 0, 0, "R5");
        // code 3 -> 14
        step(1, 13, 3, 0, 0, 0, 0, "R2");
        step(1, 14, 3, 0, 0, 0, 0, "R2");
        step(1, 16, 3, 0, 1, 0, 0, "R5");
        step(1, 0, 3, 0, 1, 0, 0, "R5");
        // R3 timeout below trigger
        step(1, 2, 3, 1, 0, 0, 0, "R3");
        step(1, 2, 3, 0, 0, 0, 0, "R4");
        step(1, 2, 3, 1, 1, 0, 0, "R5");   // timeout beats clear
        step(1, 2, 3, 0, 1, 0, 0, "R5");
        // R6/R7 transmit
        step(1, 0, 3, 0, 0, 1, 0, "R6");
        step(1, 0, 3, 0, 0, 1, 0, "R6");
        step(1, 0, 3, 0, 0, 0, 0, "R6");
        for (int i = 0; i < 4; i++) step(1, 0, 3, 0, 0, 0, 0, "R7");
        step(1, 0, 3, 0, 0, 0, 1, "R7");
        for (int i = 0; i < 6; i++) step(1, 0, 3, 0, 0, 0, 0, "R7");
        step(1, 0, 3, 0, 0, 1, 0, "R7");
        step(1, 0, 3, 0, 0, 0, 1, "R7");   // edge beats clear
        step(1, 0, 3, 0, 0, 0, 0, "R7");
        // R9 isolation
        step(1, 0, 3, 1, 0, 0, 0, "R9");
        step(1, 0, 3, 0, 1, 0, 0, "R9");   // rx cleared, tx held
        step(1, 0, 3, 1, 0, 0, 0, "R9");
        step(1, 0, 3, 0, 0, 0, 1, "R9");   // tx cleared, rx held
        // R8 mode off
        step(1, 0, 3, 0, 0, 1, 0, "R8");
        step(1, 0, 3, 0, 0, 0, 0, "R8");
        step(0, 0, 3, 0, 0, 0, 0, "R8");
        step(0, 16, 0, 1, 0, 1, 0, "R8");
        step(0, 16, 0, 1, 0, 0, 0, "R8");
        step(1, 0, 3, 0, 0, 0, 0, "R8");
        step(1, 0, 3, 0, 0, 0, 0, "R8");
        repeat (3) @(posedge clk);
        #5;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule